// File: doc/BRIEF.md
# Probe-Loadable Demonstration Counter

A 32-bit free-running up-counter meant to show off the paths between a management controller and a user design area. The controller can reach it in two ways. One is a Wishbone slave at a single word address. The other is a 128-line probe bus, where each line has an active-low enable that says whether the controller is driving it. The count is always visible on the low 32 probe-sample lines and on the general-purpose output pads.

The counter can be loaded over Wishbone with byte-select masking. It can also be loaded from probe lines 63..32, bit by bit, for each line whose enable is low. The counter's clock and its synchronous reset are normally the bus clock and bus reset. When probe line 64 is enabled, it becomes the counter clock. When probe line 65 is enabled, it becomes the counter reset. This lets the controller single-step the counter from software.

Top module: `probe_counter`

## Requirements
- R1: While the selected reset is high at a counter clock edge, the count becomes 0 and `wb_ack` becomes 0. The reset is synchronous and active high.
- R2: At each counter clock edge with no reset, no Wishbone write and no probe load, the count increases by exactly one.
- R3: A Wishbone write is a request with `wb_cyc`, `wb_stb` and `wb_we` high, `wb_ack` low, and `wb_adr[31:2]` equal to `BASE_ADDR[31:2]`. At the next edge, each byte whose `wb_sel` bit is 1 (bit k selects count bits 8k+7..8k) takes the write data. Every other byte keeps its value from before that edge. There is no increment on that edge.
- R4: `wb_ack` goes high for exactly one cycle, on the edge after a matching request. For a read, `wb_dat_r` then holds the count from before that edge. A request at any other address gives no ack and does not change the count.
- R5: When any of `la_oen_n[63:32]` is 0, each enabled bit k+32 loads count bit k from `la_drive[k+32]`. The other bits hold, and there is no increment. When all of these enables are 1, the load path has no effect.
- R6: Precedence at an edge is reset first, then a Wishbone write, then a probe load, then increment.
- R7: `la_sample[31:0]` always equals the count. `la_sample[127:32]` is always 0.
- R8: `pad_out` equals `count[PAD_W-1:0]`. `pad_oe_n` is all zeros, so every pad is driven.
- R9: When `la_oen_n[64]` is 0, the counter is clocked by `la_drive[64]` and edges of `bus_clk` have no effect.
- R10: When `la_oen_n[65]` is 0, the counter reset is `la_drive[65]` and `bus_rst` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | System bus clock |
| bus_rst | input | 1 | System bus reset, active high |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_sel | input | 4 | Wishbone byte selects |
| wb_adr | input | 32 | Wishbone byte address |
| wb_dat_w | input | 32 | Wishbone write data |
| wb_dat_r | output | 32 | Wishbone read data |
| wb_ack | output | 1 | Wishbone acknowledge |
| la_drive | input | 128 | Probe values driven by the controller |
| la_oen_n | input | 128 | Probe enables, active low (0 = controller drives the line) |
| la_sample | output | 128 | Probe values returned to the controller |
| pad_out | output | PAD_W | Pad output values |
| pad_oe_n | output | PAD_W | Pad output enables, active low |

## Verification
The bench goes after the cases where two sources meet in one cycle. A Wishbone write lands on the same edge as a full probe load; a design with the wrong order would show the probe value instead of the written one. A reset arrives together with a write; a wrong design would acknowledge it or keep the data. A partial-byte write and a partial probe load are both applied; a design that got these wrong would disturb the bytes or bits it should keep, or still increment them. Finally, the counter is stepped through the probe clock while `bus_rst` is held high and `bus_clk` keeps running. A faulty clock or reset select would count bus edges, or stay stuck at zero instead of reading 5.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int CNT_W = 32;
    localparam int SEL_W = CNT_W / 8;
    localparam int LA_W  = 128;

    typedef enum logic [1:0] {
        OP_INC   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_WRITE = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic             wr;
        logic [CNT_W-1:0] mask;
        logic [CNT_W-1:0] data;
    } wr_req_t;

    function automatic logic [CNT_W-1:0] sel_to_mask(input logic [SEL_W-1:0] sel);
        logic [CNT_W-1:0] m;
        for (int b = 0; b < SEL_W; b++) begin
            m[b*8 +: 8] = {8{sel[b]}};
        end
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] merge(input logic [CNT_W-1:0] old_v,
                                               input logic [CNT_W-1:0] new_v,
                                               input logic [CNT_W-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/pc_clk_sel.sv
module pc_clk_sel (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic probe_clk,
    input  logic probe_clk_oen_n,
    input  logic probe_rst,
    input  logic probe_rst_oen_n,
    output logic cnt_clk,
    output logic cnt_rst
);
    // An enable of 0 hands the line to the controller.
    assign cnt_clk = probe_clk_oen_n ? bus_clk : probe_clk;
    assign cnt_rst = probe_rst_oen_n ? bus_rst : probe_rst;
endmodule

// File: rtl/pc_wb_port.sv
module pc_wb_port
    import pc_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h3000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [29:0]      adr_word,
    input  logic [CNT_W-1:0] dat_w,
    input  logic [CNT_W-1:0] cur_count,
    output logic [CNT_W-1:0] dat_r,
    output logic             ack,
    output wr_req_t          wreq
);
    logic hit;
    logic take;

    assign hit  = (adr_word == BASE_ADDR[31:2]);
    assign take = cyc && stb && hit && !ack;

    always_comb begin
        wreq.wr   = take && we;
        wreq.mask = sel_to_mask(sel);
        wreq.data = dat_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            dat_r <= '0;
        end else begin
            ack <= take;
            if (take && !we) begin
                dat_r <= cur_count;
            end
        end
    end
endmodule

// File: rtl/pc_count_core.sv
module pc_count_core
    import pc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wreq,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] load_en,
    output logic [CNT_W-1:0] count
);
    cnt_op_e op;

    always_comb begin
        if (wreq.wr)       op = OP_WRITE;
        else if (|load_en) op = OP_LOAD;
        else               op = OP_INC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (op)
                OP_WRITE: count <= merge(count, wreq.data, wreq.mask);
                OP_LOAD:  count <= merge(count, load_val, load_en);
                default:  count <= count + 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/probe_counter.sv
module probe_counter
    import pc_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h3000_0000,
    parameter int          PAD_W     = 16
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             wb_cyc,
    input  logic             wb_stb,
    input  logic             wb_we,
    input  logic [SEL_W-1:0] wb_sel,
    input  logic [31:0]      wb_adr,
    input  logic [CNT_W-1:0] wb_dat_w,
    output logic [CNT_W-1:0] wb_dat_r,
    output logic             wb_ack,
    input  logic [LA_W-1:0]  la_drive,
    input  logic [LA_W-1:0]  la_oen_n,
    output logic [LA_W-1:0]  la_sample,
    output logic [PAD_W-1:0] pad_out,
    output logic [PAD_W-1:0] pad_oe_n
);
    localparam int LOAD_LO = CNT_W;
    localparam int CLK_BIT = 2 * CNT_W;
    localparam int RST_BIT = CLK_BIT + 1;

    logic             cnt_clk;
    logic             cnt_rst;
    logic [CNT_W-1:0] count;
    wr_req_t          wreq;
    logic             unused_in;

    pc_clk_sel u_sel (
        .bus_clk        (bus_clk),
        .bus_rst        (bus_rst),
        .probe_clk      (la_drive[CLK_BIT]),
        .probe_clk_oen_n(la_oen_n[CLK_BIT]),
        .probe_rst      (la_drive[RST_BIT]),
        .probe_rst_oen_n(la_oen_n[RST_BIT]),
        .cnt_clk        (cnt_clk),
        .cnt_rst        (cnt_rst)
    );

    pc_wb_port #(.BASE_ADDR(BASE_ADDR)) u_wb (
        .clk      (cnt_clk),
        .rst      (cnt_rst),
        .cyc      (wb_cyc),
        .stb      (wb_stb),
        .we       (wb_we),
        .sel      (wb_sel),
        .adr_word (wb_adr[31:2]),
        .dat_w    (wb_dat_w),
        .cur_count(count),
        .dat_r    (wb_dat_r),
        .ack      (wb_ack),
        .wreq     (wreq)
    );

    pc_count_core u_core (
        .clk     (cnt_clk),
        .rst     (cnt_rst),
        .wreq    (wreq),
        .load_val(la_drive[LOAD_LO +: CNT_W]),
        .load_en (~la_oen_n[LOAD_LO +: CNT_W]),
        .count   (count)
    );

    assign la_sample = {{(LA_W-CNT_W){1'b0}}, count};

    for (genvar p = 0; p < PAD_W; p++) begin : g_pad
        assign pad_out[p]  = count[p % CNT_W];
        assign pad_oe_n[p] = 1'b0;
    end

    assign unused_in = ^{wb_adr[1:0], la_drive[LA_W-1:RST_BIT+1], la_drive[CNT_W-1:0],
                         la_oen_n[LA_W-1:RST_BIT+1], la_oen_n[CNT_W-1:0]};
endmodule

// File: rtl/pc_checker.sv
module pc_checker
    import pc_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h3000_0000
) (
    input logic             clk,
    input logic             rst,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_we,
    input logic [SEL_W-1:0] wb_sel,
    input logic [29:0]      wb_adr_w,
    input logic [CNT_W-1:0] wb_dat_w,
    input logic             wb_ack,
    input logic [CNT_W-1:0] load_oen_n,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] count
);
    logic req, wr;
    assign req = wb_cyc && wb_stb && (wb_adr_w == BASE_ADDR[31:2]);
    assign wr  = req && wb_we && !wb_ack;

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (count == '0) && !wb_ack);

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (rst) wb_ack |=> !wb_ack);

    // R4
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst) wb_ack |-> $past(req));

    // R3
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && wb_sel == '1) |=> count == $past(wb_dat_w));

    // R5
    full_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr && load_oen_n == '0) |=> count == $past(load_val));

    // R2
    increment_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr && load_oen_n == '1) |=> count == $past(count) + 1'b1);
endmodule

bind probe_counter pc_checker #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (cnt_clk),
    .rst       (cnt_rst),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_sel    (wb_sel),
    .wb_adr_w  (wb_adr[31:2]),
    .wb_dat_w  (wb_dat_w),
    .wb_ack    (wb_ack),
    .load_oen_n(la_oen_n[63:32]),
    .load_val  (la_drive[63:32]),
    .count     (la_sample[31:0])
);

// File: tb/test_probe_counter.sv
module test_probe_counter;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h3000_0000;
    localparam int          PW         = 16;

    logic          bus_clk = 1'b0;
    logic          bus_rst;
    logic          wb_cyc, wb_stb, wb_we;
    logic [3:0]    wb_sel;
    logic [31:0]   wb_adr, wb_dat_w, wb_dat_r;
    logic          wb_ack;
    logic [127:0]  la_drive, la_oen_n, la_sample;
    logic [PW-1:0] pad_out, pad_oe_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    probe_counter #(.BASE_ADDR(BASE), .PAD_W(PW)) i_probe_counter (
        .bus_clk(bus_clk), .bus_rst(bus_rst),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .la_drive(la_drive), .la_oen_n(la_oen_n), .la_sample(la_sample),
        .pad_out(pad_out), .pad_oe_n(pad_oe_n)
    );

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;

    function automatic logic [31:0] cnt();
        return la_sample[31:0];
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_req(input logic we, input logic [31:0] adr,
                           input logic [3:0] sel, input logic [31:0] d);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we;
        wb_adr = adr; wb_sel = sel; wb_dat_w = d;
    endtask

    task automatic bus_idle();
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", cnt(), 0);
        chk("R1 ack", wb_ack, 0);
        chk("R7 upper sample", la_sample[127:32], 0);
        chk("R8 pad enables", pad_oe_n, 0);
        bus_rst = 1'b0;
    endtask

    task automatic t_increment();
        repeat (10) @(negedge bus_clk);
        chk("R2 ten edges", cnt(), 10);
        chk("R8 pads", pad_out, 10);
    endtask

    task automatic t_write();
        logic [31:0] c;
        bus_req(1'b1, BASE, 4'hF, 32'h2710);
        @(negedge bus_clk);
        chk("R4 write ack", wb_ack, 1);
        chk("R3 full write", cnt(), 32'h2710);
        bus_idle();
        @(negedge bus_clk);
        chk("R4 ack one cycle", wb_ack, 0);
        chk("R2 after write", cnt(), 32'h2711);
        c = cnt();
        bus_req(1'b1, BASE + 32'h2, 4'b0010, 32'hAABBCCDD);
        @(negedge bus_clk);
        chk("R3 byte write", cnt(), (c & 32'hFFFF00FF) | 32'h0000CC00);
        bus_idle();
        @(negedge bus_clk);
    endtask

    task automatic t_read_miss();
        logic [31:0] c;
        c = cnt();
        bus_req(1'b0, BASE, 4'hF, 32'h0);
        @(negedge bus_clk);
        chk("R4 read ack", wb_ack, 1);
        chk("R4 read data", wb_dat_r, c);
        chk("R2 read keeps counting", cnt(), c + 1);
        bus_idle();
        @(negedge bus_clk);
        c = cnt();
        bus_req(1'b1, BASE + 32'h100, 4'hF, 32'h0);
        @(negedge bus_clk);
        chk("R4 miss no ack", wb_ack, 0);
        chk("R4 miss no write", cnt(), c + 1);
        bus_idle();
    endtask

    task automatic t_probe_load();
        logic [31:0] c;
        la_oen_n[63:32] = '0;
        la_drive[63:32] = 32'h1234_5678;
        @(negedge bus_clk);
        chk("R5 full load", cnt(), 32'h1234_5678);
        @(negedge bus_clk);
        chk("R5 held while enabled", cnt(), 32'h1234_5678);
        la_oen_n[63:32] = 32'hFFFF_FF00;
        la_drive[63:32] = 32'h0000_00AB;
        c = cnt();
        @(negedge bus_clk);
        chk("R5 partial load", cnt(), (c & 32'hFFFF_FF00) | 32'hAB);
        la_oen_n[63:32] = '1;
        c = cnt();
        @(negedge bus_clk);
        chk("R5 disabled no effect", cnt(), c + 1);
    endtask

    task automatic t_precedence();
        la_oen_n[63:32] = '0;
        la_drive[63:32] = 32'h55;
        bus_req(1'b1, BASE, 4'hF, 32'h99);
        @(negedge bus_clk);
        chk("R6 write over load", cnt(), 32'h99);
        bus_idle();
        @(negedge bus_clk);
        chk("R6 load after write", cnt(), 32'h55);
        la_oen_n[63:32] = '1;
        bus_rst = 1'b1;
        bus_req(1'b1, BASE, 4'hF, 32'h77);
        @(negedge bus_clk);
        chk("R6 reset over write", cnt(), 0);
        chk("R1 reset blocks ack", wb_ack, 0);
        bus_idle();
        bus_rst = 1'b0;
        @(negedge bus_clk);
    endtask

    task automatic t_probe_clock();
        la_drive[64] = 1'b0;
        la_drive[65] = 1'b1;
        la_oen_n[65:64] = 2'b00;
        repeat (2) begin
            #1 la_drive[64] = 1'b1;
            #1 la_drive[64] = 1'b0;
        end
        chk("R10 probe reset", cnt(), 0);
        la_drive[65] = 1'b0;
        bus_rst = 1'b1;
        repeat (5) begin
            #1 la_drive[64] = 1'b1;
            #1 la_drive[64] = 1'b0;
        end
        #1;
        chk("R9 five probe edges", cnt(), 5);
        repeat (3) @(negedge bus_clk);
        chk("R9 bus clock ignored", cnt(), 5);
        chk("R10 bus reset ignored", pad_out, 5);
        la_oen_n[65:64] = 2'b11;
        bus_rst = 1'b0;
    endtask

    initial begin
        bus_rst = 1'b1;
        bus_idle();
        wb_adr = '0; wb_sel = '0; wb_dat_w = '0;
        la_drive = '0;
        la_oen_n = '1;
        repeat (3) @(negedge bus_clk);
        t_reset();
        t_increment();
        t_write();
        t_read_miss();
        t_probe_load();
        t_precedence();
        t_probe_clock();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule